// File: doc/BRIEF.md
# Immediate-Operand Integer ALU

This block executes the integer operations whose second operand is a 16-bit immediate field: a wrapping add, an add that traps on signed overflow, signed and unsigned set-less-than, bitwise AND, OR and XOR, and load-upper. The caller presents an operation code, the 32-bit source register value and the raw immediate together with a valid strobe. One clock later the block returns the result, a destination write-enable and two exception flags.

Each operation extends the immediate in its own way. The adds and both compares sign-extend it. The unsigned compare therefore compares against a sign-extended value, but compares it as unsigned. The three logical operations zero-extend it. When the trapping add overflows, the block raises the overflow flag and withholds the write. The doubleword add-immediate codes, and every code the block does not decode, are reported as reserved instructions and never write.

Top module: `imm_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `outValid`, `wrEn`, `ovfExc` and `rsvdExc` are all 0 after that edge.
- R2: Outputs are registered. `outValid` equals the `inValid` of the previous clock edge. When `outValid` is 0, `wrEn`, `ovfExc` and `rsvdExc` are 0.
- R3: Opcodes 0 (trapping add) and 1 (wrapping add) produce `rsVal` plus the sign-extended immediate, modulo 2^32. Opcode 1 never raises `ovfExc`.
- R4: For opcode 0, `ovfExc` is 1 exactly when `rsVal` and the extended immediate share a sign bit and the sum's sign bit differs from it. Examples: 0x7FFFFFFF+0x0001 and 0x80000000+0xFFFF.
- R5: Opcode 2 writes 1 if `rsVal` is less than the sign-extended immediate as signed numbers, and 0 otherwise.
- R6: Opcode 3 sign-extends the immediate and then compares unsigned, writing 1 or 0.
- R7: Opcodes 4 (AND), 5 (OR) and 6 (XOR) combine `rsVal` with the zero-extended immediate.
- R8: Opcode 7 places the immediate in bits 31:16 and zeros in bits 15:0.
- R9: Opcodes 8 and 9 (doubleword add-immediate) and 10 to 15 raise `rsvdExc`, keep `wrEn` at 0, never raise `ovfExc`, and drive `result` to 0.
- R10: For a valid decoded operation that does not overflow, `wrEn` is 1 and `ovfExc` and `rsvdExc` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation presented this cycle |
| opSel | input | 4 | Operation code (see requirements) |
| rsVal | input | DATA_W | Source register value |
| immVal | input | IMM_W | Raw immediate field |
| outValid | output | 1 | Registered result is valid |
| result | output | DATA_W | Registered result |
| wrEn | output | 1 | Destination register write-enable |
| ovfExc | output | 1 | Signed overflow exception (trapping add) |
| rsvdExc | output | 1 | Reserved-instruction exception |

## Verification
The bench builds the block with its default widths, DATA_W of 32 and IMM_W of 16. These widths make the two signed-overflow boundaries reachable: the positive limit plus one, and the negative limit plus an all-ones immediate. They also expose the unsigned compare against a sign-extended 0xFFFF, where an immediate whose top bit is set becomes the largest unsigned values. Random operands with forced extreme values exercise the sign-bit cases of every opcode, including each reserved code.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_TRAP  = 4'd0,
    OP_ADD_WRAP  = 4'd1,
    OP_SLT_S     = 4'd2,
    OP_SLT_U     = 4'd3,
    OP_AND       = 4'd4,
    OP_OR        = 4'd5,
    OP_XOR       = 4'd6,
    OP_LOAD_HI   = 4'd7,
    OP_DADD_TRAP = 4'd8,
    OP_DADD_WRAP = 4'd9
  } aluOp_e;

  localparam logic [OP_W-1:0] RSVD_BASE = 4'd8;

  // Strobes from control to datapath; at most one select is high.
  typedef struct packed {
    logic selAdd;
    logic selSltS;
    logic selSltU;
    logic selAnd;
    logic selOr;
    logic selXor;
    logic selLoadHi;
    logic trapOvf;
    logic reserved;
  } aluStrobe_t;
endpackage

// File: rtl/imm_alu_ctrl.sv
module imm_alu_ctrl
  import imm_alu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluStrobe_t      strobe
);
  always_comb begin
    strobe = '0;
    case (aluOp_e'(opSel))
      OP_ADD_TRAP: begin
        strobe.selAdd  = 1'b1;
        strobe.trapOvf = 1'b1;
      end
      OP_ADD_WRAP: strobe.selAdd    = 1'b1;
      OP_SLT_S:    strobe.selSltS   = 1'b1;
      OP_SLT_U:    strobe.selSltU   = 1'b1;
      OP_AND:      strobe.selAnd    = 1'b1;
      OP_OR:       strobe.selOr     = 1'b1;
      OP_XOR:      strobe.selXor    = 1'b1;
      OP_LOAD_HI:  strobe.selLoadHi = 1'b1;
      default:     strobe.reserved  = 1'b1;
    endcase
  end
endmodule

// File: rtl/imm_alu_dp.sv
module imm_alu_dp
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  aluStrobe_t        strobe,
  input  logic [DATA_W-1:0] rsVal,
  input  logic [IMM_W-1:0]  immVal,
  output logic [DATA_W-1:0] resultNext,
  output logic              ovfRaw
);
  localparam int EXT_W = DATA_W - IMM_W;
  localparam int MSB   = DATA_W - 1;

  logic [DATA_W-1:0] immSext;
  logic [DATA_W-1:0] immZext;
  logic [DATA_W-1:0] immHigh;
  logic [DATA_W-1:0] sum;
  logic              ltSigned;
  logic              ltUnsigned;

  generate
    if (EXT_W > 0) begin : g_extend
      assign immSext = {{EXT_W{immVal[IMM_W-1]}}, immVal};
      assign immZext = {{EXT_W{1'b0}}, immVal};
      assign immHigh = {immVal, {EXT_W{1'b0}}};
    end else begin : g_same
      assign immSext = immVal[DATA_W-1:0];
      assign immZext = immVal[DATA_W-1:0];
      assign immHigh = immVal[DATA_W-1:0];
    end
  endgenerate

  assign sum        = rsVal + immSext;
  assign ovfRaw     = (rsVal[MSB] == immSext[MSB]) && (sum[MSB] != rsVal[MSB]);
  assign ltSigned   = $signed(rsVal) < $signed(immSext);
  assign ltUnsigned = rsVal < immSext;

  always_comb begin
    resultNext = '0;
    if (strobe.selAdd)    resultNext = sum;
    if (strobe.selSltS)   resultNext = {{(DATA_W-1){1'b0}}, ltSigned};
    if (strobe.selSltU)   resultNext = {{(DATA_W-1){1'b0}}, ltUnsigned};
    if (strobe.selAnd)    resultNext = rsVal & immZext;
    if (strobe.selOr)     resultNext = rsVal | immZext;
    if (strobe.selXor)    resultNext = rsVal ^ immZext;
    if (strobe.selLoadHi) resultNext = immHigh;
  end
endmodule

// File: rtl/imm_alu.sv
module imm_alu
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [OP_W-1:0]   opSel,
  input  logic [DATA_W-1:0] rsVal,
  input  logic [IMM_W-1:0]  immVal,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              wrEn,
  output logic              ovfExc,
  output logic              rsvdExc
);
  aluStrobe_t        strobe;
  logic [DATA_W-1:0] resultNext;
  logic              ovfRaw;
  logic              ovfHit;

  imm_alu_ctrl ctrl_i (
    .opSel  (opSel),
    .strobe (strobe)
  );

  imm_alu_dp #(.DATA_W(DATA_W), .IMM_W(IMM_W)) dp_i (
    .strobe     (strobe),
    .rsVal      (rsVal),
    .immVal     (immVal),
    .resultNext (resultNext),
    .ovfRaw     (ovfRaw)
  );

  assign ovfHit = strobe.trapOvf & ovfRaw;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      wrEn     <= 1'b0;
      ovfExc   <= 1'b0;
      rsvdExc  <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= inValid;
      wrEn     <= inValid & ~strobe.reserved & ~ovfHit;
      ovfExc   <= inValid & ovfHit;
      rsvdExc  <= inValid & strobe.reserved;
      if (inValid) result <= resultNext;
    end
  end
endmodule

// File: rtl/imm_alu_checker.sv
module imm_alu_checker
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [OP_W-1:0]   opSel,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              wrEn,
  input logic              ovfExc,
  input logic              rsvdExc
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!outValid && !wrEn && !ovfExc && !rsvdExc)); // R1

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid); // R2

  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> (!wrEn && !ovfExc && !rsvdExc)); // R2

  AST_WRAP_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (inValid && opSel == OP_ADD_WRAP) |=> !ovfExc); // R3

  AST_NO_WRITE_ON_OVF: assert property (@(posedge clk) disable iff (rst)
    ovfExc |-> !wrEn); // R4

  AST_SLT_BOOLEAN: assert property (@(posedge clk) disable iff (rst)
    (inValid && (opSel == OP_SLT_S || opSel == OP_SLT_U)) |=> (result[DATA_W-1:1] == '0)); // R5

  AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (rst)
    (inValid && opSel >= RSVD_BASE) |=> (rsvdExc && !wrEn && !ovfExc && result == '0)); // R9

  AST_DECODED_WRITES: assert property (@(posedge clk) disable iff (rst)
    (inValid && opSel != OP_ADD_TRAP && opSel < RSVD_BASE) |=> (wrEn && !rsvdExc)); // R10

  AST_EXC_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ovfExc && rsvdExc)); // R9
endmodule

bind imm_alu imm_alu_checker #(.DATA_W(DATA_W)) checker_i (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .opSel    (opSel),
  .outValid (outValid),
  .result   (result),
  .wrEn     (wrEn),
  .ovfExc   (ovfExc),
  .rsvdExc  (rsvdExc)
);

// File: tb/imm_alu_tb_top.sv
module imm_alu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int IMM_W      = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              inValid = 1'b0;
  logic [3:0]        opSel = '0;
  logic [DATA_W-1:0] rsVal = '0;
  logic [IMM_W-1:0]  immVal = '0;
  logic              outValid;
  logic [DATA_W-1:0] result;
  logic              wrEn;
  logic              ovfExc;
  logic              rsvdExc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  imm_alu #(.DATA_W(DATA_W), .IMM_W(IMM_W)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .rsVal(rsVal), .immVal(immVal), .outValid(outValid), .result(result),
    .wrEn(wrEn), .ovfExc(ovfExc), .rsvdExc(rsvdExc)
  );

  function automatic logic [31:0] sext(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0: return "R4";
      4'd1: return "R3";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4, 4'd5, 4'd6: return "R7";
      4'd7: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Expected {result, wrEn, ovfExc, rsvdExc}
  function automatic logic [34:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [15:0] im);
    logic [31:0] s;
    logic [31:0] r;
    logic ov;
    s  = a + sext(im);
    ov = (a[31] == im[15]) && (s[31] != a[31]);
    r  = '0;
    case (op)
      4'd0: begin r = s; return {r, !ov, ov, 1'b0}; end
      4'd1: r = s;
      4'd2: r = {31'b0, $signed(a) < $signed(sext(im))};
      4'd3: r = {31'b0, a < sext(im)};
      4'd4: r = a & {16'b0, im};
      4'd5: r = a | {16'b0, im};
      4'd6: r = a ^ {16'b0, im};
      4'd7: r = {im, 16'b0};
      default: return {32'b0, 1'b0, 1'b0, 1'b1};
    endcase
    return {r, 1'b1, 1'b0, 1'b0};
  endfunction

  task automatic check(input string req, input string what, input logic [34:0] act,
                       input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual res=%h we=%b ovf=%b rsv=%b expected res=%h we=%b ovf=%b rsv=%b",
               req, what, act[34:3], act[2], act[1], act[0], exp[34:3], exp[2], exp[1], exp[0]);
    end
  endtask

  // Drive at negedge, result registered at next posedge, sample at following negedge.
  task automatic runOp(input logic [3:0] op, input logic [31:0] a, input logic [15:0] im,
                       input string what);
    inValid = 1'b1; opSel = op; rsVal = a; immVal = im;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check(reqOf(op), what, {result, wrEn, ovfExc, rsvdExc}, model(op, a, im));
    check("R2", {what, " valid"}, {34'b0, outValid}, 35'd1);
    if (op < 4'd8 && !(op == 4'd0 && model(op, a, im)[1]))
      check("R10", {what, " write"}, {32'b0, wrEn, ovfExc, rsvdExc}, {32'b0, 3'b100});
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", "reset", {32'b0, outValid, wrEn, ovfExc, rsvdExc}, 35'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R2", "idle", {32'b0, outValid, wrEn, ovfExc, rsvdExc}, 35'd0);

    runOp(4'd0, 32'h7FFFFFFF, 16'h0001, "R4 pos limit +1");
    runOp(4'd0, 32'h80000000, 16'hFFFF, "R4 neg limit -1");
    runOp(4'd0, 32'h7FFFFFFF, 16'hFFFF, "R4 mixed sign no ovf");
    runOp(4'd1, 32'h7FFFFFFF, 16'h0001, "R3 wrap no trap");
    runOp(4'd1, 32'h80000000, 16'hFFFF, "R3 wrap neg");
    runOp(4'd2, 32'h00000005, 16'hFFFF, "R5 5 < -1 false");
    runOp(4'd2, 32'h80000000, 16'h0000, "R5 min < 0");
    runOp(4'd3, 32'h00000005, 16'hFFFF, "R6 5 <u 0xFFFFFFFF");
    runOp(4'd3, 32'hFFFFFFFF, 16'hFFFF, "R6 equal");
    runOp(4'd4, 32'hFFFFFFFF, 16'h8000, "R7 and zext");
    runOp(4'd5, 32'h12340000, 16'h8001, "R7 or zext");
    runOp(4'd6, 32'hFFFFFFFF, 16'hFFFF, "R7 xor zext");
    runOp(4'd7, 32'hDEADBEEF, 16'hABCD, "R8 load high");
    runOp(4'd8, 32'h7FFFFFFF, 16'h0001, "R9 dword trap add");
    runOp(4'd9, 32'h00000001, 16'h0001, "R9 dword wrap add");
    runOp(4'd12, 32'h00000001, 16'h0001, "R9 unused code");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      logic [15:0] im;
      logic [3:0]  op;
      a  = $urandom;
      im = 16'($urandom);
      op = 4'($urandom % 16);
      case ($urandom % 6)
        0: a = 32'h7FFFFFFF - 32'($urandom % 4);
        1: a = 32'h80000000 + 32'($urandom % 4);
        2: im = ($urandom % 2) ? 16'hFFFF : 16'h8000;
        default: ;
      endcase
      runOp(op, a, im, "random");
      if (($urandom % 8) == 0) begin
        @(negedge clk);
        check("R2", "gap idle", {32'b0, outValid, wrEn, ovfExc, rsvdExc}, 35'd0);
      end
    end

    // R1 reset during activity
    inValid = 1'b1; opSel = 4'd8; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "mid reset", {32'b0, outValid, wrEn, ovfExc, rsvdExc}, 35'd0);
    inValid = 1'b0; rst = 1'b0;
    @(negedge clk);
    finish();
  end
endmodule